// File: doc/BRIEF.md
# Sector Erase Command Decoder

This block sits between the external write bus of a NOR-style flash device and its internal erase sequencer. It watches active-low write-enable strobes, takes the address on the falling edge of the strobe and the data on the rising edge, and checks each completed write against a six-write sector-erase sequence. The sequence is two unlock writes, a setup write, two more unlock writes, and a sector-erase command. Any write that breaks the sequence sends the block back to read mode without starting anything.

Once the first sector-erase command is accepted, the block opens a collection window of a fixed number of clock cycles. Each further sector-erase command inside the window marks its sector in an eight-bit pending map and restarts the window. Sectors may be added in any order, and the same sector may be added more than once. When the window runs out, the block publishes the pending map as the erase selection and gives the erase sequencer a one-cycle start pulse. Any other write inside the window drops the pending selection and returns the block to read mode.

Top module: `sect_erase_cmd`

## Requirements
- R1: After synchronous reset, `read_mode_o` is 1, `erase_start_o` is 0 and `erase_map_o` is all zeros.
- R2: The accepted sequence is data AAh at address 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh, then 30h at any address. Only the low 11 address bits take part in the address compares. `read_mode_o` drops to 0 after the first correct write.
- R3: A wrong address or a wrong data value in any of the six writes returns `read_mode_o` to 1, and no start pulse follows.
- R4: The address of a write is the value on `addr` when the block first sees `we_n` low. The data is the value on `data` when the block first sees `we_n` high again. Changes to either between those two points have no effect.
- R5: The sector of a sector-erase write is `addr[13:11]`. Bit i of `erase_map_o` selects sector i.
- R6: `erase_start_o` is high for exactly one cycle, WINDOW_CYC+1 clock cycles after the clock edge that sees the rising strobe of the last accepted 30h write. It never rises earlier.
- R7: A further 30h write inside the window adds its sector to the pending map and restarts the full window from that write.
- R8: A write other than 30h inside the window returns the block to read mode, drops the pending map, and no start pulse follows.
- R9: The published map is the union of every sector written inside one window, regardless of order or repetition.
- R10: `erase_map_o` holds its value from one start pulse until the next. `read_mode_o` is 1 in the cycle the start pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| we_n | input | 1 | Active-low write strobe of the external bus |
| addr | input | 14 | Bus address, top 3 bits are the sector number |
| data | input | 8 | Bus write data |
| read_mode_o | output | 1 | 1 in read mode, 0 while a command sequence is in progress |
| erase_start_o | output | 1 | One-cycle pulse that launches the erase |
| erase_map_o | output | 8 | One-hot-per-sector selection published with the start pulse |

## Verification
A sequence state that has slipped shows up on `read_mode_o` two clock edges after the rising strobe of the write that should have moved it. It also shows up as a start pulse that is missing or comes when it should not. A window counter that is off by even one cycle moves the start pulse away from the exact cycle the bench samples. A pending-map fault stays hidden until the window closes, and then `erase_map_o` differs from the union the bench computed from the addresses it wrote.

// File: rtl/sect_erase_pkg.sv
`timescale 1ns/1ps
package sect_erase_pkg;

    localparam int DATA_W      = 8;
    localparam int ADR_KEY1    = 'h555;
    localparam int ADR_KEY2    = 'h2AA;
    localparam logic [DATA_W-1:0] DAT_KEY1  = 8'hAA;
    localparam logic [DATA_W-1:0] DAT_KEY2  = 8'h55;
    localparam logic [DATA_W-1:0] DAT_SETUP = 8'h80;
    localparam logic [DATA_W-1:0] DAT_SECT  = 8'h30;

    typedef enum logic [2:0] {
        ST_READ, ST_KEY1, ST_KEY2, ST_ARMED, ST_KEY3, ST_KEY4, ST_WINDOW
    } seq_state_e;

    typedef enum logic [2:0] {
        K_UNLOCK_A, K_UNLOCK_B, K_SETUP, K_SECTOR, K_OTHER
    } cmd_kind_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              at_key1;
        logic              at_key2;
    } bus_ev_t;

    function automatic cmd_kind_e classify(bus_ev_t ev);
        if (ev.data == DAT_SECT)                    return K_SECTOR;
        if (ev.data == DAT_KEY1  && ev.at_key1)     return K_UNLOCK_A;
        if (ev.data == DAT_KEY2  && ev.at_key2)     return K_UNLOCK_B;
        if (ev.data == DAT_SETUP && ev.at_key1)     return K_SETUP;
        return K_OTHER;
    endfunction

endpackage

// File: rtl/sect_erase_capture.sv
`timescale 1ns/1ps
module sect_erase_capture
    import sect_erase_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int SECT_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data,
    output bus_ev_t              ev_o,
    output logic [SECT_BITS-1:0] sect_o
);
    localparam int CMD_AW = ADDR_W - SECT_BITS;

    logic                 we_q;
    logic                 k1_lat, k2_lat;
    logic [SECT_BITS-1:0] sect_lat;
    logic                 fall, rise;

    assign fall = we_q & ~we_n;
    assign rise = ~we_q & we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q     <= 1'b1;
            k1_lat   <= 1'b0;
            k2_lat   <= 1'b0;
            sect_lat <= '0;
            ev_o     <= '0;
            sect_o   <= '0;
        end else begin
            we_q       <= we_n;
            ev_o.valid <= rise;
            if (fall) begin
                k1_lat   <= (addr[CMD_AW-1:0] == CMD_AW'(ADR_KEY1));
                k2_lat   <= (addr[CMD_AW-1:0] == CMD_AW'(ADR_KEY2));
                sect_lat <= addr[ADDR_W-1 -: SECT_BITS];
            end
            if (rise) begin
                ev_o.data    <= data;
                ev_o.at_key1 <= k1_lat;
                ev_o.at_key2 <= k2_lat;
                sect_o       <= sect_lat;
            end
        end
    end

    // a rising strobe yields one event, never two in a row (R4)
    p_single_event_r4: assert property (@(posedge clk) disable iff (rst)
        ev_o.valid |=> !ev_o.valid);

endmodule

// File: rtl/sect_erase_timer.sv
`timescale 1ns/1ps
module sect_erase_timer #(
    parameter int WINDOW_CYC = 6250
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic halt,
    output logic expired
);
    localparam int CNT_W = $clog2(WINDOW_CYC);

    logic [CNT_W-1:0] cnt;
    logic             running;

    assign expired = running && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= CNT_W'(WINDOW_CYC - 1);
        end else if (halt) begin
            running <= 1'b0;
        end else if (running && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // a reload always restarts the full window (R7)
    p_reload_full_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> running && cnt == CNT_W'(WINDOW_CYC - 1));

    // the counter never wraps while running (R6)
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (running && !load && !halt && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/sect_erase_buffer.sv
`timescale 1ns/1ps
module sect_erase_buffer #(
    parameter int SECT_BITS = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   add,
    input  logic [SECT_BITS-1:0]   idx,
    input  logic                   clr,
    input  logic                   launch,
    output logic [(1<<SECT_BITS)-1:0] map_o
);
    localparam int NSECT = 1 << SECT_BITS;

    logic [NSECT-1:0] pend;

    for (genvar i = 0; i < NSECT; i++) begin : g_sect
        always_ff @(posedge clk) begin
            if (rst || clr || launch)
                pend[i] <= 1'b0;
            else if (add && idx == SECT_BITS'(i))
                pend[i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            map_o <= '0;
        else if (launch)
            map_o <= pend;
    end

    // an accepted sector stays marked (R9)
    p_add_marks_r9: assert property (@(posedge clk) disable iff (rst)
        (add && !clr && !launch) |=> pend[$past(idx)]);

    // an abort drops the whole selection (R8)
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> pend == '0);

    // published map only moves on a launch (R10)
    p_map_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !launch |=> $stable(map_o));

endmodule

// File: rtl/sect_erase_seq.sv
`timescale 1ns/1ps
module sect_erase_seq
    import sect_erase_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    expired,
    output logic    buf_add,
    output logic    buf_clr,
    output logic    launch,
    output logic    tmr_load,
    output logic    tmr_halt,
    output logic    read_mode_o,
    output logic    start_o
);
    seq_state_e state, state_nx;
    cmd_kind_e  kind;

    assign kind        = classify(ev);
    assign read_mode_o = (state == ST_READ);

    always_comb begin
        state_nx = state;
        buf_add  = 1'b0;
        buf_clr  = 1'b0;
        launch   = 1'b0;
        tmr_load = 1'b0;
        tmr_halt = 1'b0;
        if (ev.valid) begin
            case (state)
                ST_READ:   if (kind == K_UNLOCK_A) state_nx = ST_KEY1;
                ST_KEY1:   state_nx = (kind == K_UNLOCK_B) ? ST_KEY2  : ST_READ;
                ST_KEY2:   state_nx = (kind == K_SETUP)    ? ST_ARMED : ST_READ;
                ST_ARMED:  state_nx = (kind == K_UNLOCK_A) ? ST_KEY3  : ST_READ;
                ST_KEY3:   state_nx = (kind == K_UNLOCK_B) ? ST_KEY4  : ST_READ;
                ST_KEY4, ST_WINDOW: begin
                    if (kind == K_SECTOR) begin
                        state_nx = ST_WINDOW;
                        buf_add  = 1'b1;
                        tmr_load = 1'b1;
                    end else begin
                        state_nx = ST_READ;
                        buf_clr  = 1'b1;
                        tmr_halt = 1'b1;
                    end
                end
                default:   state_nx = ST_READ;
            endcase
        end else if (state == ST_WINDOW && expired) begin
            state_nx = ST_READ;
            launch   = 1'b1;
            tmr_halt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_READ;
            start_o <= 1'b0;
        end else begin
            state   <= state_nx;
            start_o <= launch;
        end
    end

    // a broken unlock or setup write ends the sequence (R3)
    p_abort_seq_r3: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && kind == K_OTHER && state != ST_READ) |=> state == ST_READ);

    // a launch only comes out of an open window (R6)
    p_launch_window_r6: assert property (@(posedge clk) disable iff (rst)
        start_o |-> $past(state) == ST_WINDOW);

endmodule

// File: rtl/sect_erase_cmd.sv
`timescale 1ns/1ps
module sect_erase_cmd
    import sect_erase_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int SECT_BITS = 3,
    parameter int CLK_MHZ   = 125,
    parameter int WINDOW_US = 50
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          data,
    output logic                       read_mode_o,
    output logic                       erase_start_o,
    output logic [(1<<SECT_BITS)-1:0]  erase_map_o
);
    localparam int WINDOW_CYC = CLK_MHZ * WINDOW_US;

    bus_ev_t              ev;
    logic [SECT_BITS-1:0] ev_sect;
    logic                 expired, buf_add, buf_clr, launch, tmr_load, tmr_halt;

    sect_erase_capture #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_capture (
        .clk(clk), .rst(rst), .we_n(we_n), .addr(addr), .data(data),
        .ev_o(ev), .sect_o(ev_sect)
    );

    sect_erase_seq u_seq (
        .clk(clk), .rst(rst), .ev(ev), .expired(expired),
        .buf_add(buf_add), .buf_clr(buf_clr), .launch(launch),
        .tmr_load(tmr_load), .tmr_halt(tmr_halt),
        .read_mode_o(read_mode_o), .start_o(erase_start_o)
    );

    sect_erase_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .halt(tmr_halt), .expired(expired)
    );

    sect_erase_buffer #(.SECT_BITS(SECT_BITS)) u_buffer (
        .clk(clk), .rst(rst), .add(buf_add), .idx(ev_sect),
        .clr(buf_clr), .launch(launch), .map_o(erase_map_o)
    );

    // start is a single-cycle pulse (R6)
    p_start_single_r6: assert property (@(posedge clk) disable iff (rst)
        erase_start_o |=> !erase_start_o);

    // the block is back in read mode when it launches (R10)
    p_start_read_r10: assert property (@(posedge clk) disable iff (rst)
        erase_start_o |-> read_mode_o && $past(!read_mode_o));

    // a launch always selects at least one sector (R5)
    p_map_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        erase_start_o |-> erase_map_o != '0);

endmodule

// File: tb/sect_erase_cmd_bench.sv
`timescale 1ns/1ps
module sect_erase_cmd_bench;

    localparam int W = 125;   // 125 MHz x 1 us window

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we_n = 1'b1;
    logic [13:0] addr = '0;
    logic [7:0]  data = '0;
    logic        read_mode_o, erase_start_o;
    logic [7:0]  erase_map_o;

    int n_checks = 0;
    int n_fail   = 0;
    int starts   = 0;

    always #4 clk = ~clk;

    sect_erase_cmd #(.WINDOW_US(1)) u_sect_erase_cmd (
        .clk(clk), .rst(rst), .we_n(we_n), .addr(addr), .data(data),
        .read_mode_o(read_mode_o), .erase_start_o(erase_start_o),
        .erase_map_o(erase_map_o)
    );

    always @(negedge clk) if (!rst && erase_start_o) starts++;

    // {count, a0, a1, a2, expected map}
    localparam logic [51:0] VECS [5] = '{
        {2'd1, 14'h0123, 14'h0000, 14'h0000, 8'h01},
        {2'd2, 14'h3800, 14'h0800, 14'h0000, 8'h82},
        {2'd3, 14'h1555, 14'h2AAA, 14'h1000, 8'h24},
        {2'd3, 14'h3000, 14'h1800, 14'h2000, 8'h58},
        {2'd1, 14'h2555, 14'h0000, 14'h0000, 8'h10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a_fall, input logic [13:0] a_late,
                      input logic [7:0] d_early, input logic [7:0] d_rise);
        @(negedge clk); addr = a_fall; data = d_early; we_n = 1'b0;
        @(negedge clk); addr = a_late; data = d_rise;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr1(input logic [13:0] a, input logic [7:0] d);
        wr(a, a, d, d);
    endtask

    task automatic preamble(input logic [2:0] up);
        wr1({up, 11'h555}, 8'hAA);
        wr1({up, 11'h2AA}, 8'h55);
        wr1({up, 11'h555}, 8'h80);
        wr1({up, 11'h555}, 8'hAA);
        wr1({up, 11'h2AA}, 8'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int s0;
        idle(3);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        chk("R1 read_mode", read_mode_o, 1);
        chk("R1 start", erase_start_o, 0);
        chk("R1 map", erase_map_o, 0);

        // R2 first unlock leaves read mode
        wr1(14'h0555, 8'hAA);
        chk("R2 after unlock", read_mode_o, 0);
        wr1(14'h02AA, 8'h55);
        wr1(14'h0555, 8'h80);
        wr1(14'h0555, 8'hAA);
        wr1(14'h02AA, 8'h55);
        chk("R2 mid sequence", read_mode_o, 0);
        wr1(14'h0800, 8'h30);
        idle(W + 4);
        chk("R2 map sector1", erase_map_o, 8'h02);

        // table walk: R5 R6 R9 R10, upper address bits vary (R2)
        for (int i = 0; i < 5; i++) begin
            logic [51:0] v;
            v = VECS[i];
            s0 = starts;
            preamble(3'(i + 1));
            wr1(v[49:36], 8'h30);
            if (v[51:50] > 2'd1) wr1(v[35:22], 8'h30);
            if (v[51:50] > 2'd2) wr1(v[21:8], 8'h30);
            idle(W - 2);
            chk("R6 no early start", starts - s0, 0);
            idle(4);
            chk("R6 one start", starts - s0, 1);
            chk("R9 union map", erase_map_o, v[7:0]);
            chk("R10 read mode after", read_mode_o, 1);
        end

        // R3 wrong setup data
        s0 = starts;
        wr1(14'h0555, 8'hAA);
        wr1(14'h02AA, 8'h55);
        wr1(14'h0555, 8'h81);
        chk("R3 bad data", read_mode_o, 1);
        // R3 wrong unlock address
        wr1(14'h0555, 8'hAA);
        wr1(14'h02AB, 8'h55);
        chk("R3 bad address", read_mode_o, 1);
        // R3 wrong final command
        preamble(3'd0);
        wr1(14'h1000, 8'h31);
        chk("R3 bad command", read_mode_o, 1);
        idle(W + 6);
        chk("R3 no start", starts - s0, 0);

        // R8 foreign write in window, map of last launch held (R10)
        s0 = starts;
        preamble(3'd0);
        wr1(14'h1800, 8'h30);
        idle(W / 2);
        chk("R8 still in window", read_mode_o, 0);
        wr1(14'h1800, 8'hF0);
        chk("R8 back to read", read_mode_o, 1);
        idle(W + 6);
        chk("R8 no start", starts - s0, 0);
        chk("R10 map held", erase_map_o, 8'h10);

        // R7 re-arm by a second sector command
        s0 = starts;
        preamble(3'd0);
        wr1(14'h0800, 8'h30);
        idle(W / 2);
        wr1(14'h3000, 8'h30);
        idle(W - 2);
        chk("R7 window restarted", starts - s0, 0);
        idle(4);
        chk("R7 one start", starts - s0, 1);
        chk("R7 both sectors", erase_map_o, 8'h42);

        // R4 address from falling strobe, data from rising strobe
        s0 = starts;
        preamble(3'd0);
        wr(14'h3800, 14'h0000, 8'h00, 8'h30);
        idle(W + 4);
        chk("R4 start", starts - s0, 1);
        chk("R4 sector from fall address", erase_map_o, 8'h80);

        // R1 reset mid sequence
        preamble(3'd0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 reset read mode", read_mode_o, 1);
        chk("R1 reset map", erase_map_o, 0);

        finish_run();
    end

endmodule